// File: doc/BRIEF.md
# Descriptor-Walking DMA Engine

This block moves data between a device-side byte buffer and system memory by following a table of region descriptors that software has placed in memory. Each descriptor takes two 32-bit little-endian words. The first word is the region start address. The second word holds the region size in its low half and an end-of-table marker in its top bit. The engine reads a descriptor, then transfers bytes region by region. It stops when the device buffer has been used up or when the table has run out, and it reports which of the two caused the stop.

A call is launched with a one-cycle `start` pulse. The pulse carries the byte count of the device buffer and the transfer direction. When `fresh` is high, the pulse also carries a new table base. A fresh call discards any partly consumed region and walks the table again from its base. A call without `fresh` keeps the fetch pointer and the current region, so a transfer that stopped in the middle of a region continues from the next unmoved byte.

Memory traffic goes through one request port with a valid/ready handshake. Reads complete when a response pulse arrives. Each memory access is a single aligned 32-bit beat with byte enables. The device buffer is reached through a byte-wide index/data port.

Top module: `prd_dma_engine`

## Requirements
- R1: A descriptor is fetched as two reads. The word at the fetch pointer gives the region start address, the word at pointer+4 gives the size word, and the pointer then advances by 8, so descriptors are consumed in table order.
- R2: The region length is size-word bits 15:0 with bit 0 forced to zero. Bits 30:16 have no effect.
- R3: A decoded length of zero stands for 65536 bytes.
- R4: Size-word bit 31 marks the final descriptor. Once that region is drained and buffer bytes remain, the call ends with `done_more`=0 and no further descriptor is fetched.
- R5: A new descriptor is never fetched once the fetch pointer is 4096 or more bytes past the table base. The call then ends with `done_more`=0.
- R6: Buffer exhaustion is tested before any fetch. When the device buffer is used up, the call ends with `done_more`=1, and a zero byte count issues no memory request.
- R7: A start with `fresh`=0 resumes inside the current region, at the byte that follows the last byte moved.
- R8: A start with `fresh`=1 clears the current region, including its final marker, and reloads the fetch pointer from `table_base`.
- R9: With `to_mem`=1, device buffer bytes 0..n-1 are written to memory from the region address onward. With `to_mem`=0, memory bytes are read into buffer bytes 0..n-1.
- R10: Every request uses a word-aligned address. Byte enables select exactly the lanes from address bits 1:0 onward that fall inside both the region and the remaining buffer, and memory bytes outside those lanes are left unchanged.
- R11: Only one request is outstanding at a time: no new request is made while a read response is pending. A request that is not yet accepted keeps its address, enables and type.
- R12: `done` is a single-cycle pulse given on return to idle, with the outcome on `done_more`. A `start` arriving while busy is ignored.
- R13: After reset the engine is idle, with no request, no buffer write and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a call (ignored while busy) |
| fresh | input | 1 | With start: reset the walk to `table_base` |
| table_base | input | ADDR_W | Descriptor table base address |
| to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| xfer_bytes | input | BUF_W | Device buffer byte count for this call |
| busy | output | 1 | Call in progress |
| done | output | 1 | One-cycle end-of-call pulse |
| done_more | output | 1 | 1: buffer used up, 0: table ended |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_be | output | 4 | Byte-lane enables |
| mem_req_wdata | output | 32 | Write data, little-endian lanes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| dev_idx | output | BUF_W | Device buffer byte index |
| dev_we | output | 1 | Device buffer byte write |
| dev_wdata | output | 8 | Device buffer write byte |
| dev_rdata | input | 8 | Device buffer byte at `dev_idx` |

## Verification
Single-descriptor tables are run with aligned and unaligned region starts, odd raw sizes, and stray high size bits in both directions. The byte count is set below, equal to and above the region length, which separates the two end codes and exposes wrong lane masks at the byte just outside each region. A zero-length descriptor followed by a non-fresh call tells a true resume apart from a restart. A fresh call after a drained final region shows that the final marker is cleared. A two-descriptor table shows ordering across regions. A 512-entry table without a final marker shows that the page limit, rather than the table contents, ends the walk. A start pulse sent mid-call must leave both the data and the done count unchanged.

// File: rtl/prd_dma_engine.sv
module prd_dma_engine #(
  parameter int ADDR_W     = 32,
  parameter int BUF_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fresh,
  input  logic [ADDR_W-1:0] table_base,
  input  logic              to_mem,
  input  logic [BUF_W-1:0]  xfer_bytes,
  output logic              busy,
  output logic              done,
  output logic              done_more,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [3:0]        mem_req_be,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic [BUF_W-1:0]  dev_idx,
  output logic              dev_we,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);

  localparam int LEN_W = 17;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(65536);
  localparam logic [ADDR_W-1:0] PAGE_LIM = ADDR_W'(PAGE_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_EVAL, S_DREQ, S_DWAIT, S_RREQ, S_RWAIT, S_SCAT, S_GATH, S_WREQ
  } st_t;

  st_t               state;
  logic [ADDR_W-1:0] base_r, fptr, rg_addr;
  logic [LEN_W-1:0]  rg_len;
  logic              rg_last, dir_r, half, done_r, more_r;
  logic [BUF_W-1:0]  buf_size, buf_idx;
  logic [1:0]        bpos;
  logic [31:0]       wbuf;

  logic [BUF_W-1:0]  buf_left;
  logic [2:0]        room, n_rg, beat_n;
  logic [1:0]        lane;
  logic              last_byte, past_page;
  logic [15:0]       raw_len;
  logic [LEN_W-1:0]  dec_len;
  logic [3:0]        be_mask;

  assign buf_left  = buf_size - buf_idx;
  assign room      = 3'd4 - {1'b0, rg_addr[1:0]};
  assign n_rg      = (rg_len < LEN_W'(room)) ? rg_len[2:0] : room;
  assign beat_n    = (buf_left < BUF_W'(n_rg)) ? buf_left[2:0] : n_rg;
  assign lane      = rg_addr[1:0] + bpos;
  assign last_byte = ({1'b0, bpos} == beat_n - 3'd1);
  assign past_page = (fptr - base_r) >= PAGE_LIM;
  assign raw_len   = {mem_rsp_data[15:1], 1'b0};
  assign dec_len   = (raw_len == 16'd0) ? LEN_MAX : {1'b0, raw_len};

  always_comb begin
    for (int k = 0; k < 4; k++)
      be_mask[k] = (3'(k) >= {1'b0, rg_addr[1:0]}) &&
                   (3'(k) <  {1'b0, rg_addr[1:0]} + beat_n);
  end

  assign mem_req_valid = (state == S_DREQ) || (state == S_RREQ) || (state == S_WREQ);
  assign mem_req_we    = (state == S_WREQ);
  assign mem_req_addr  = (state == S_DREQ) ? fptr + (half ? ADDR_W'(4) : ADDR_W'(0))
                                           : {rg_addr[ADDR_W-1:2], 2'b00};
  assign mem_req_be    = (state == S_DREQ) ? 4'hF : be_mask;
  assign mem_req_wdata = wbuf;
  assign dev_idx       = buf_idx + BUF_W'(bpos);
  assign dev_we        = (state == S_SCAT);
  assign dev_wdata     = 8'(wbuf >> {lane, 3'b000});
  assign busy          = (state != S_IDLE);
  assign done          = done_r;
  assign done_more     = more_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      base_r   <= '0;
      fptr     <= '0;
      rg_addr  <= '0;
      rg_len   <= '0;
      rg_last  <= 1'b0;
      dir_r    <= 1'b0;
      half     <= 1'b0;
      done_r   <= 1'b0;
      more_r   <= 1'b0;
      buf_size <= '0;
      buf_idx  <= '0;
      bpos     <= '0;
      wbuf     <= '0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (fresh) begin
            rg_addr <= '0;
            rg_len  <= '0;
            rg_last <= 1'b0;
            fptr    <= table_base;
            base_r  <= table_base;
          end
          buf_size <= xfer_bytes;
          buf_idx  <= '0;
          dir_r    <= to_mem;
          state    <= S_EVAL;
        end
        S_EVAL: begin
          bpos <= '0;
          if (buf_idx >= buf_size) begin
            done_r <= 1'b1;
            more_r <= 1'b1;
            state  <= S_IDLE;
          end else if (rg_len == '0) begin
            if (rg_last || past_page) begin
              done_r <= 1'b1;
              more_r <= 1'b0;
              state  <= S_IDLE;
            end else begin
              half  <= 1'b0;
              state <= S_DREQ;
            end
          end else begin
            state <= dir_r ? S_GATH : S_RREQ;
          end
        end
        S_DREQ: if (mem_req_ready) state <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          if (!half) begin
            rg_addr <= ADDR_W'(mem_rsp_data);
            half    <= 1'b1;
            state   <= S_DREQ;
          end else begin
            rg_len  <= dec_len;
            rg_last <= mem_rsp_data[31];
            fptr    <= fptr + ADDR_W'(8);
            state   <= S_EVAL;
          end
        end
        S_RREQ: if (mem_req_ready) state <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin
          wbuf  <= mem_rsp_data;
          state <= S_SCAT;
        end
        S_SCAT: begin
          if (last_byte) begin
            rg_addr <= rg_addr + ADDR_W'(beat_n);
            rg_len  <= rg_len - LEN_W'(beat_n);
            buf_idx <= buf_idx + BUF_W'(beat_n);
            state   <= S_EVAL;
          end else begin
            bpos <= bpos + 2'd1;
          end
        end
        S_GATH: begin
          wbuf[{lane, 3'b000} +: 8] <= dev_rdata;
          if (last_byte) state <= S_WREQ;
          else           bpos  <= bpos + 2'd1;
        end
        S_WREQ: if (mem_req_ready) begin
          rg_addr <= rg_addr + ADDR_W'(beat_n);
          rg_len  <= rg_len - LEN_W'(beat_n);
          buf_idx <= buf_idx + BUF_W'(beat_n);
          state   <= S_EVAL;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prd_dma_engine_sva.sv
module prd_dma_engine_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [3:0]        mem_req_be,
  input logic              mem_rsp_valid,
  input logic              dev_we
);

  logic rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)                                      rd_pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) rd_pend <= 1'b1;
    else if (mem_rsp_valid)                          rd_pend <= 1'b0;
  end

  p_single_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_req_valid);

  p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_be) && $stable(mem_req_we)));

  p_word_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00 && mem_req_be != 4'h0));

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !dev_we));

endmodule

bind prd_dma_engine prd_dma_engine_sva #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/prd_dma_engine_tb_top.sv
module prd_dma_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, fresh = 1'b0, to_mem = 1'b0;
  logic [31:0] table_base = '0;
  logic [15:0] xfer_bytes = '0;
  logic        busy, done, done_more;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [15:0] dev_idx;
  logic        dev_we;
  logic [7:0]  dev_wdata, dev_rdata;

  always #4 clk = ~clk;

  prd_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fresh(fresh), .table_base(table_base),
    .to_mem(to_mem), .xfer_bytes(xfer_bytes), .busy(busy), .done(done), .done_more(done_more),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dev_idx(dev_idx), .dev_we(dev_we), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  logic [31:0] mem [2048];
  logic [7:0]  dev [2048];
  assign dev_rdata = dev[dev_idx[10:0]];

  int checks = 0, errors = 0;
  int nreq, nhigh, nwrb, ndev, ndone, nwide, rcnt;
  logic last_more, pend, done_prev;
  logic [31:0] pend_a;

  function automatic logic [7:0] mpat(input logic [31:0] a);
    return 8'(a * 32'd37) ^ 8'(a >> 3);
  endfunction
  function automatic logic [7:0] dpat(input int i);
    return 8'(i * 7 + 200);
  endfunction
  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return 8'(mem[a[12:2]] >> {a[1:0], 3'b000});
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; pend = 1'b0; done_prev = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mem[pend_a[12:2]]; pend = 1'b0;
      end
      rcnt++;
      mem_req_ready = (rcnt % 3) != 2;
      if (mem_req_valid && mem_req_ready) begin
        nreq++;
        if (mem_req_addr >= 32'h2000) nhigh++;
        if (mem_req_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_req_be[k]) begin
              mem[mem_req_addr[12:2]][8*k +: 8] = mem_req_wdata[8*k +: 8];
              nwrb++;
            end
        end else begin
          pend = 1'b1; pend_a = mem_req_addr;
        end
      end
      if (dev_we) begin dev[dev_idx[10:0]] = dev_wdata; ndev++; end
      if (done) begin ndone++; last_more = done_more; if (done_prev) nwide++; end
      done_prev = done;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int w = 0; w < 2048; w++)
      mem[w] = {mpat(32'(4*w+3)), mpat(32'(4*w+2)), mpat(32'(4*w+1)), mpat(32'(4*w))};
  endtask
  task automatic init_dev();
    for (int i = 0; i < 2048; i++) dev[i] = dpat(i);
  endtask
  task automatic put_word(input logic [31:0] a, input logic [31:0] v);
    mem[a[12:2]] = v;
  endtask
  task automatic clr();
    nreq = 0; nhigh = 0; nwrb = 0; ndev = 0; ndone = 0;
  endtask
  task automatic launch(input logic [31:0] b, input logic [15:0] n, input bit d, input bit f);
    @(negedge clk);
    start = 1'b1; fresh = f; table_base = b; xfer_bytes = n; to_mem = d;
    @(negedge clk);
    start = 1'b0;
  endtask
  task automatic wait_done(input int limit);
    bit got = 0;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (ndone != 0) begin got = 1; break; end
    end
    if (!got) chk(0, "R12", "watchdog expired", 0, 1);
    repeat (2) @(negedge clk);
  endtask
  task automatic chk_rd(input string tag, input logic [31:0] a, input int n, input int skip);
    int bad = -1;
    for (int i = 0; i < n; i++)
      if (bad < 0 && dev[i] != mpat(a + 32'(skip + i))) bad = i;
    chk(bad < 0, tag, "read data mismatch byte", bad, -1);
    chk(dev[n] == dpat(n), tag, "buffer byte past end", dev[n], dpat(n));
  endtask
  task automatic chk_wr(input string tag, input logic [31:0] a, input int n, input int first);
    int bad = -1;
    for (int i = 0; i < n; i++)
      if (bad < 0 && mbyte(a + 32'(i)) != dpat(first + i)) bad = i;
    chk(bad < 0, tag, "write data mismatch byte", bad, -1);
    chk(mbyte(a - 1) == mpat(a - 1), "R10", "byte before region", mbyte(a - 1), mpat(a - 1));
    chk(mbyte(a + 32'(n)) == mpat(a + 32'(n)), "R10", "byte after region",
        mbyte(a + 32'(n)), mpat(a + 32'(n)));
  endtask

  typedef struct packed {
    logic [31:0] raddr;
    logic [31:0] size;
    logic [15:0] xfer;
    logic        dir;
    logic        more;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h0100, 32'h8000_0010, 16'd16, 1'b0, 1'b1},
    '{32'h0103, 32'h8000_0009, 16'd20, 1'b0, 1'b0},
    '{32'h0202, 32'h8000_000B, 16'd7,  1'b1, 1'b1},
    '{32'h0301, 32'h8000_0020, 16'd40, 1'b1, 1'b0},
    '{32'h0405, 32'h8000_0006, 16'd0,  1'b0, 1'b1},
    '{32'h0500, 32'h8001_0004, 16'd9,  1'b1, 1'b0}
  };

  initial begin
    int len, moved;
    clr(); rcnt = 0; last_more = 1'b0;
    init_mem(); init_dev();
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_req_valid && !dev_we, "R13", "outputs in reset", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy, "R13", "busy after reset", busy, 0);
    chk(!mem_req_valid, "R13", "request after reset", mem_req_valid, 0);
    chk(ndone == 0 && nreq == 0, "R13", "activity after reset", ndone + nreq, 0);

    foreach (VEC[v]) begin
      init_mem(); init_dev(); clr();
      put_word(32'h1000, VEC[v].raddr);
      put_word(32'h1004, VEC[v].size);
      len = int'(VEC[v].size[15:0] & 16'hFFFE);
      if (len == 0) len = 65536;
      moved = (int'(VEC[v].xfer) < len) ? int'(VEC[v].xfer) : len;
      launch(32'h1000, VEC[v].xfer, VEC[v].dir, 1'b1);
      wait_done(5000);
      chk(last_more == VEC[v].more, VEC[v].more ? "R6" : "R4", "end code", last_more, VEC[v].more);
      if (VEC[v].dir) begin
        chk(nwrb == moved, "R2", "bytes written", nwrb, moved);
        chk_wr("R9", VEC[v].raddr, moved, 0);
      end else begin
        chk(ndev == moved, "R2", "bytes read", ndev, moved);
        chk_rd("R9", VEC[v].raddr, moved, 0);
      end
      if (VEC[v].xfer == 0) chk(nreq == 0, "R6", "requests for empty buffer", nreq, 0);
    end

    init_mem(); init_dev(); clr();
    put_word(32'h1000, 32'h0200);
    put_word(32'h1004, 32'h8000_0000);
    launch(32'h1000, 16'd300, 1'b0, 1'b1);
    wait_done(10000);
    chk(last_more == 1'b1, "R3", "zero-length region end code", last_more, 1);
    chk(ndev == 300, "R3", "bytes from zero-length region", ndev, 300);
    chk_rd("R3", 32'h0200, 300, 0);
    init_dev(); clr();
    launch(32'h1000, 16'd100, 1'b0, 1'b0);
    wait_done(5000);
    chk(last_more == 1'b1, "R7", "resume end code", last_more, 1);
    chk(nreq == 25, "R7", "resume requests (no refetch)", nreq, 25);
    chk_rd("R7", 32'h0200, 100, 300);

    put_word(32'h1800, 32'h0600);
    put_word(32'h1804, 32'h8000_0008);
    init_dev(); clr();
    launch(32'h1800, 16'd8, 1'b0, 1'b1);
    wait_done(5000);
    chk(last_more == 1'b1, "R8", "fresh table end code", last_more, 1);
    chk_rd("R8", 32'h0600, 8, 0);
    init_dev(); clr();
    launch(32'h1800, 16'd20, 1'b0, 1'b1);
    wait_done(5000);
    chk(last_more == 1'b0 && ndev == 8, "R8", "refetch after final region", ndev, 8);

    init_mem(); init_dev(); clr();
    put_word(32'h1000, 32'h0700);
    put_word(32'h1004, 32'h0000_0005);
    put_word(32'h1008, 32'h0781);
    put_word(32'h100C, 32'h8000_0006);
    launch(32'h1000, 16'd64, 1'b1, 1'b1);
    wait_done(5000);
    chk(last_more == 1'b0, "R4", "two-entry table end code", last_more, 0);
    chk(nwrb == 10, "R1", "bytes over two regions", nwrb, 10);
    chk_wr("R1", 32'h0700, 4, 0);
    chk_wr("R1", 32'h0781, 6, 4);

    init_mem(); init_dev(); clr();
    for (int i = 0; i < 512; i++) begin
      put_word(32'h1000 + 32'(8*i), 32'h0100);
      put_word(32'h1004 + 32'(8*i), 32'h0000_0002);
    end
    launch(32'h1000, 16'd1100, 1'b0, 1'b1);
    wait_done(30000);
    chk(last_more == 1'b0, "R5", "page limit end code", last_more, 0);
    chk(ndev == 1024, "R5", "bytes before page limit", ndev, 1024);
    chk(nhigh == 0, "R5", "fetches past page", nhigh, 0);

    init_mem(); init_dev(); clr();
    put_word(32'h1000, 32'h0340);
    put_word(32'h1004, 32'h8000_0010);
    put_word(32'h1800, 32'h0380);
    put_word(32'h1804, 32'h8000_0010);
    launch(32'h1000, 16'd16, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    start = 1'b1; fresh = 1'b1; table_base = 32'h1800; xfer_bytes = 16'd2; to_mem = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(5000);
    repeat (20) @(negedge clk);
    chk(ndone == 1, "R12", "done count with start while busy", ndone, 1);
    chk(nwrb == 0 && ndev == 16, "R12", "busy start ignored", nwrb, 0);
    chk_rd("R12", 32'h0340, 16, 0);
    chk(nwide == 0, "R12", "done pulses wider than one cycle", nwide, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule